// File: doc/BRIEF.md
# NAND flash command cycle engine

This block turns queued 32-bit command words into bus cycles on a raw NAND flash device. Software writes a word into a small command queue through a simple register port. A sequencer takes words from the queue one at a time. Each word becomes one of three things: a single command byte with the command latch enable high, a single address byte with the address latch enable high, or a burst of data bytes. Write bursts take bytes from a byte-stream source, and read bursts deliver bytes to a byte-stream sink; both streams are normally served by a DMA engine.

Every strobe on the write-enable or read-enable pin is held low for a parameterised number of clocks and then high for the same number. A word can ask the engine to wait until the ready/busy pin shows the device is ready again, and a programmable timeout guards that wait. When an operation completes, a status register records it: command done, transmit-burst done, receive-burst done, or command error. Each status bit is cleared by writing a one to the same bit position of a separate clear register. A level interrupt output reports completion of words that ask for it.

Top module: `nand_cycle_engine`

## Requirements
- R1: While reset is held and right after it, the status register reads 0, the write-enable and read-enable pins are high, both latch enables are low, the IO output enable is low and irq is low.
- R2: A word written to offset 0x000 with bits [17:16] = 1 gives exactly one write-enable strobe with the command latch enable high, the address latch enable low and IO = bits [7:0]. With bits [17:16] = 0, the same holds with the address latch enable high and the command latch enable low.
- R3: Each write-enable or read-enable strobe stays low for STROBE_CLKS clocks (default 2) and then high for STROBE_CLKS clocks.
- R4: A word with bits [17:16] = 2 and length field bits [11:0] = N gives N+1 write-enable strobes with both latch enables low. Each strobe carries the next byte accepted from the transmit stream (taken when tx_valid and tx_ready are both high). No strobe occurs while tx_valid is low. Status bit 6 is set when the burst finishes.
- R5: A word with bits [17:16] = 3 and length N gives N+1 read-enable strobes and no write-enable strobe. The byte on nand_io_in is sampled at the end of each low phase and delivered in order as a one-clock rx_valid pulse. IO is never driven while read-enable is low. Status bit 7 is set when the burst finishes.
- R6: Status bit 9 (command done) is set when a word with bit 18 (last cycle) set finishes. A word with bit 18 clear does not set it.
- R7: When bit 19 (wait for ready) is set, the word does not finish while nand_rb_n is low. It finishes once nand_rb_n has been high for the two clocks of its synchroniser.
- R8: The timeout register at offset 0x008 reads back what was written to it (reset value TMO_RESET). If a ready wait lasts longer than that many clocks, status bit 11 (command error) is set, the word is abandoned and bit 9 is not set.
- R9: The command queue holds FIFO_DEPTH words (default 4). A write to offset 0x000 while the queue is full is discarded and sets status bit 11. Queued words run in order.
- R10: Writing a one to a bit at offset 0x120 clears that status bit. A status event in the same clock as the clear wins, so the bit stays set. Offset 0x118 reads the status register.
- R11: irq rises when a word with bit 13 set finishes, and falls when status bit 9 is cleared through offset 0x120.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (status or timeout) |
| tx_valid | input | 1 | Transmit stream byte available |
| tx_data | input | 8 | Transmit stream byte |
| tx_ready | output | 1 | Engine can take a transmit byte |
| rx_valid | output | 1 | Received byte pulse |
| rx_data | output | 8 | Received byte |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_io_out | output | 8 | IO bus output value |
| nand_io_oe | output | 1 | IO bus output enable |
| nand_io_in | input | 8 | IO bus input value |
| nand_rb_n | input | 1 | Ready/busy, low while busy |
| irq | output | 1 | Completion interrupt level |

## Verification
A write to the clear register and a completion event on the same status bit can land in the same clock. That is the case where the order of set and clear decides the result. The bench provokes it by watching the write-enable pin of a single command word rise, counting the remaining high phase and the finishing cycle, and timing the clear of bit 9 so it is sampled on the same edge that records the completion. It then expects bit 9 still set, and expects a second, isolated clear to take it to zero. A second case pushes words into the queue while the sequencer is blocked in a ready wait. It judges the dropped word by counting the strobes that reach the pins once the device turns ready.

// File: rtl/nce_pkg.sv
package nce_pkg;
  localparam int unsigned STAT_W = 13;
  localparam int unsigned LEN_W  = 12;

  localparam logic [11:0] OFS_CMD  = 12'h000;
  localparam logic [11:0] OFS_TMO  = 12'h008;
  localparam logic [11:0] OFS_STAT = 12'h118;
  localparam logic [11:0] OFS_CLR  = 12'h120;

  localparam int unsigned B_WFR   = 19;
  localparam int unsigned B_LAST  = 18;
  localparam int unsigned B_CT_LO = 16;
  localparam int unsigned B_IWC   = 13;

  localparam int unsigned S_TXDONE = 6;
  localparam int unsigned S_RXDONE = 7;
  localparam int unsigned S_DONE   = 9;
  localparam int unsigned S_ERR    = 11;

  typedef enum logic [1:0] {
    CT_ADDR  = 2'd0,
    CT_CMD   = 2'd1,
    CT_WRITE = 2'd2,
    CT_READ  = 2'd3
  } cyc_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_ARM, SQ_LOW, SQ_HIGH, SQ_WAIT, SQ_FIN
  } sq_e;

  typedef struct packed {
    logic done;
    logic tx;
    logic rx;
    logic iwc;
    logic tmo;
  } ev_t;
endpackage

// File: rtl/nce_cmd_fifo.sv
module nce_cmd_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         ovf_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wp_q, rp_q, wp_d, rp_d;
  logic         full, push_ok;

  assign empty_o = (wp_q == rp_q);
  assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign push_ok = push_i && !full;
  assign ovf_o   = push_i && full;
  assign head_o  = mem_q[rp_q[AW-1:0]];

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (push_ok) wp_d = wp_q + 1'b1;
    if (pop_i && !empty_o) rp_d = rp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wp_q[AW-1:0]] <= data_i;
  end

  logic [AW:0] fill;
  assign fill = wp_q - rp_q;

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (AW+1)'(DEPTH));

  a_r9_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !pop_i) |=> (fill == $past(fill)));
endmodule

// File: rtl/nce_seq.sv
module nce_seq
  import nce_pkg::*;
#(
  parameter int unsigned STROBE = 2,
  parameter int unsigned TMO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             empty_i,
  input  logic [31:0]      head_i,
  output logic             pop_o,
  input  logic [TMO_W-1:0] tmo_lim_i,
  input  logic             tx_valid_i,
  input  logic [7:0]       tx_data_i,
  output logic             tx_ready_o,
  output logic             rx_valid_o,
  output logic [7:0]       rx_data_o,
  output logic             cle_o,
  output logic             ale_o,
  output logic             we_n_o,
  output logic             re_n_o,
  output logic [7:0]       io_out_o,
  output logic             io_oe_o,
  input  logic [7:0]       io_in_i,
  input  logic             rb_n_i,
  output ev_t              ev_o
);
  localparam int unsigned CW = $clog2(STROBE + 1);

  sq_e              st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  cyc_e             ty_q, ty_d;
  logic             wfr_q, wfr_d, last_q, last_d, iwc_q, iwc_d;
  logic [7:0]       byte_q, byte_d;
  logic [TMO_W-1:0] tcnt_q, tcnt_d;
  logic [1:0]       rbs_q;
  logic             rxv_q, rxv_d;
  logic [7:0]       rxd_q, rxd_d;
  logic             strobe_end, active;

  logic unused_hd;
  assign unused_hd = ^{head_i[31:20], head_i[15:14], head_i[12]};

  assign strobe_end = (cnt_q == CW'(STROBE - 1));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    ty_d   = ty_q;
    wfr_d  = wfr_q;
    last_d = last_q;
    iwc_d  = iwc_q;
    byte_d = byte_q;
    tcnt_d = tcnt_q;
    rxv_d  = 1'b0;
    rxd_d  = rxd_q;
    pop_o      = 1'b0;
    tx_ready_o = 1'b0;
    ev_o       = '0;
    case (st_q)
      SQ_IDLE: begin
        if (!empty_i) begin
          pop_o  = 1'b1;
          ty_d   = cyc_e'(head_i[B_CT_LO +: 2]);
          wfr_d  = head_i[B_WFR];
          last_d = head_i[B_LAST];
          iwc_d  = head_i[B_IWC];
          byte_d = head_i[7:0];
          rem_d  = head_i[B_CT_LO+1] ? head_i[LEN_W-1:0] : '0;
          st_d   = SQ_ARM;
        end
      end
      SQ_ARM: begin
        if (ty_q == CT_WRITE) begin
          tx_ready_o = 1'b1;
          if (tx_valid_i) begin
            byte_d = tx_data_i;
            cnt_d  = '0;
            st_d   = SQ_LOW;
          end
        end else begin
          cnt_d = '0;
          st_d  = SQ_LOW;
        end
      end
      SQ_LOW: begin
        if (strobe_end) begin
          cnt_d = '0;
          st_d  = SQ_HIGH;
          if (ty_q == CT_READ) begin
            rxv_d = 1'b1;
            rxd_d = io_in_i;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_HIGH: begin
        if (strobe_end) begin
          cnt_d = '0;
          if (rem_q != '0) begin
            rem_d = rem_q - 1'b1;
            st_d  = SQ_ARM;
          end else if (wfr_q) begin
            tcnt_d = '0;
            st_d   = SQ_WAIT;
          end else begin
            st_d = SQ_FIN;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_WAIT: begin
        if (rbs_q[1]) begin
          st_d = SQ_FIN;
        end else if (tcnt_q >= tmo_lim_i) begin
          ev_o.tmo = 1'b1;
          st_d     = SQ_IDLE;
        end else begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      SQ_FIN: begin
        ev_o.done = last_q;
        ev_o.tx   = (ty_q == CT_WRITE);
        ev_o.rx   = (ty_q == CT_READ);
        ev_o.iwc  = iwc_q;
        st_d      = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      rem_q  <= '0;
      ty_q   <= CT_ADDR;
      wfr_q  <= 1'b0;
      last_q <= 1'b0;
      iwc_q  <= 1'b0;
      byte_q <= '0;
      tcnt_q <= '0;
      rbs_q  <= 2'b11;
      rxv_q  <= 1'b0;
      rxd_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      ty_q   <= ty_d;
      wfr_q  <= wfr_d;
      last_q <= last_d;
      iwc_q  <= iwc_d;
      byte_q <= byte_d;
      tcnt_q <= tcnt_d;
      rbs_q  <= {rbs_q[0], rb_n_i};
      rxv_q  <= rxv_d;
      rxd_q  <= rxd_d;
    end
  end

  assign active     = (st_q == SQ_ARM) || (st_q == SQ_LOW) || (st_q == SQ_HIGH);
  assign cle_o      = active && (ty_q == CT_CMD);
  assign ale_o      = active && (ty_q == CT_ADDR);
  assign we_n_o     = !((st_q == SQ_LOW) && (ty_q != CT_READ));
  assign re_n_o     = !((st_q == SQ_LOW) && (ty_q == CT_READ));
  assign io_oe_o    = active && (ty_q != CT_READ);
  assign io_out_o   = byte_q;
  assign rx_valid_o = rxv_q;
  assign rx_data_o  = rxd_q;

  a_r2_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle_o && ale_o));

  a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n_o |-> !io_oe_o);

  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_WAIT && !rbs_q[1]) |=> (st_q != SQ_FIN));

  a_r8_tmo_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_o.tmo |=> (st_q == SQ_IDLE));

  generate
    if (STROBE > 1) begin : g_hold
      a_r3_we_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n_o) |=> !we_n_o);
      a_r3_re_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(re_n_o) |=> !re_n_o);
    end
  endgenerate
endmodule

// File: rtl/nce_status.sv
module nce_status
  import nce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_i,
  input  logic              iwc_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] stat_q, stat_d, clr_eff;
  logic              irq_q, irq_d;

  always_comb begin
    clr_eff = clr_we_i ? clr_i : '0;
    stat_d  = (stat_q & ~clr_eff) | set_i;
    irq_d   = (irq_q & ~clr_eff[S_DONE]) | iwc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i[S_DONE] |=> stat_q[S_DONE]);

  a_r10_clear_err: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && clr_i[S_ERR] && !set_i[S_ERR]) |=> !stat_q[S_ERR]);

  a_r11_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    iwc_i |=> irq_q);
endmodule

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine
  import nce_pkg::*;
#(
  parameter int unsigned    FIFO_DEPTH  = 4,
  parameter int unsigned    STROBE_CLKS = 2,
  parameter int unsigned    TMO_W       = 16,
  parameter logic [TMO_W-1:0] TMO_RESET = 16'd1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tx_valid,
  input  logic [7:0]  tx_data,
  output logic        tx_ready,
  output logic        rx_valid,
  output logic [7:0]  rx_data,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_io_out,
  output logic        nand_io_oe,
  input  logic [7:0]  nand_io_in,
  input  logic        nand_rb_n,
  output logic        irq
);
  logic              push, pop, empty, ovf, clr_we, tmo_we;
  logic [31:0]       head;
  logic [TMO_W-1:0]  tmo_q, tmo_d;
  logic [STAT_W-1:0] set_mask, stat;
  ev_t               ev;

  assign push   = reg_wr && (reg_addr == OFS_CMD);
  assign clr_we = reg_wr && (reg_addr == OFS_CLR);
  assign tmo_we = reg_wr && (reg_addr == OFS_TMO);

  always_comb begin
    tmo_d = tmo_q;
    if (tmo_we) tmo_d = reg_wdata[TMO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmo_q <= TMO_RESET;
    else        tmo_q <= tmo_d;
  end

  nce_cmd_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .data_i  (reg_wdata),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (empty),
    .ovf_o   (ovf)
  );

  nce_seq #(.STROBE(STROBE_CLKS), .TMO_W(TMO_W)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .empty_i    (empty),
    .head_i     (head),
    .pop_o      (pop),
    .tmo_lim_i  (tmo_q),
    .tx_valid_i (tx_valid),
    .tx_data_i  (tx_data),
    .tx_ready_o (tx_ready),
    .rx_valid_o (rx_valid),
    .rx_data_o  (rx_data),
    .cle_o      (nand_cle),
    .ale_o      (nand_ale),
    .we_n_o     (nand_we_n),
    .re_n_o     (nand_re_n),
    .io_out_o   (nand_io_out),
    .io_oe_o    (nand_io_oe),
    .io_in_i    (nand_io_in),
    .rb_n_i     (nand_rb_n),
    .ev_o       (ev)
  );

  always_comb begin
    set_mask           = '0;
    set_mask[S_DONE]   = ev.done;
    set_mask[S_TXDONE] = ev.tx;
    set_mask[S_RXDONE] = ev.rx;
    set_mask[S_ERR]    = ev.tmo | ovf;
  end

  nce_status i_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_mask),
    .clr_we_i (clr_we),
    .clr_i    (reg_wdata[STAT_W-1:0]),
    .iwc_i    (ev.iwc),
    .stat_o   (stat),
    .irq_o    (irq)
  );

  always_comb begin
    case (reg_addr)
      OFS_STAT: reg_rdata = {{(32-STAT_W){1'b0}}, stat};
      OFS_TMO:  reg_rdata = {{(32-TMO_W){1'b0}}, tmo_q};
      default:  reg_rdata = '0;
    endcase
  end

  a_r9_ovf_flags_err: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> stat[S_ERR]);
endmodule

// File: tb/test_nand_cycle_engine.sv
module test_nand_cycle_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe, irq;
  logic [7:0]  nand_io_out, nand_io_in;
  logic        nand_rb_n;

  always #4 clk = ~clk;

  nand_cycle_engine i_nand_cycle_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n),
    .irq(irq)
  );

  localparam logic [11:0] A_CMD = 12'h000, A_TMO = 12'h008,
                          A_STAT = 12'h118, A_CLR = 12'h120;

  // expected {done, irq, cle, ale, io[7:0]}
  localparam logic [31:0] VEC_W [4] = '{32'h0005_0070, 32'h0000_00A5,
                                        32'h0004_003C, 32'h0005_20FF};
  localparam logic [11:0] VEC_E [4] = '{12'hA70, 12'h1A5, 12'h93C, 12'hEFF};

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // NAND device / DMA models
  logic [9:0] cap_buf [64];
  int         cap_cnt = 0;
  int         we_lo = 0, we_low_w = 0, re_lo = 0, re_low_w = 0;
  logic [7:0] rx_buf [64];
  int         rx_cnt = 0;
  bit         conflict = 0;
  logic [7:0] tx_idx = 0, rd_idx = 0;

  assign tx_data    = 8'h30 + tx_idx;
  assign nand_io_in = 8'hC0 + rd_idx;

  always @(posedge clk) if (tx_valid && tx_ready) tx_idx <= tx_idx + 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_we_n) we_lo = we_lo + 1;
      else begin
        if (we_lo > 0) begin
          if (cap_cnt < 64) cap_buf[cap_cnt] = {nand_cle, nand_ale, nand_io_out};
          cap_cnt  = cap_cnt + 1;
          we_low_w = we_lo;
        end
        we_lo = 0;
      end
      if (!nand_re_n) re_lo = re_lo + 1;
      else begin
        if (re_lo > 0) begin
          re_low_w = re_lo;
          rd_idx   = rd_idx + 1'b1;
        end
        re_lo = 0;
      end
      if (rx_valid) begin
        if (rx_cnt < 64) rx_buf[rx_cnt] = rx_data;
        rx_cnt = rx_cnt + 1;
      end
      if (!nand_re_n && nand_io_oe) conflict = 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = A_STAT;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = A_STAT;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = A_STAT; reg_wdata = '0;
    tx_valid = 1'b0; nand_rb_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    chk("R1 status", reg_rdata, 32'h0);
    chk("R1 pins", {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe, irq}, 6'b110000);
    rst_n = 1'b1;
    idle(2);
    rd(A_STAT, v); chk("R1 status after release", v, 32'h0);

    // R2, R6, R11 vector table
    for (int i = 0; i < 4; i++) begin
      base = cap_cnt;
      wr(A_CMD, VEC_W[i]);
      idle(20);
      chk("R2 strobe count", cap_cnt - base, 1);
      chk("R2 latch and byte", {22'd0, cap_buf[base]}, {22'd0, VEC_E[i][9:0]});
      rd(A_STAT, v);
      chk("R6 done bit", v[9], VEC_E[i][11]);
      chk("R11 irq", irq, VEC_E[i][10]);
      wr(A_CLR, 32'h1FFF);
      idle(1);
      chk("R11 irq cleared", irq, 1'b0);
    end
    chk("R3 WE low width", we_low_w, 2);

    // R4 data write burst
    base = cap_cnt;
    wr(A_CMD, 32'h0006_0003);
    idle(10);
    chk("R4 stall without tx_valid", cap_cnt - base, 0);
    tx_valid = 1'b1;
    idle(60);
    tx_valid = 1'b0;
    chk("R4 strobe count", cap_cnt - base, 4);
    for (int k = 0; k < 4; k++)
      chk("R4 data byte", {22'd0, cap_buf[base+k]}, {22'd0, 2'b00, 8'h30 + 8'(k)});
    rd(A_STAT, v); chk("R4 status tx and done", v, 32'h240);
    wr(A_CLR, 32'h1FFF);

    // R5 data read burst
    base = cap_cnt;
    wr(A_CMD, 32'h0007_0004);
    idle(60);
    chk("R5 rx count", rx_cnt, 5);
    for (int k = 0; k < 5; k++)
      chk("R5 rx byte", {24'd0, rx_buf[k]}, {24'd0, 8'hC0 + 8'(k)});
    chk("R5 no WE strobe", cap_cnt - base, 0);
    chk("R5 no IO drive during read", conflict, 1'b0);
    chk("R3 RE low width", re_low_w, 2);
    rd(A_STAT, v); chk("R5 status rx and done", v, 32'h280);
    wr(A_CLR, 32'h1FFF);

    // R7 wait for ready
    nand_rb_n = 1'b0;
    wr(A_CMD, 32'h000D_0090);
    idle(30);
    rd(A_STAT, v); chk("R7 held while busy", v, 32'h0);
    nand_rb_n = 1'b1;
    idle(10);
    rd(A_STAT, v); chk("R7 done after ready", v, 32'h200);
    wr(A_CLR, 32'h1FFF);

    // R8 timeout
    wr(A_TMO, 32'd10);
    rd(A_TMO, v); chk("R8 timeout readback", v, 32'd10);
    nand_rb_n = 1'b0;
    wr(A_CMD, 32'h000D_0091);
    idle(40);
    rd(A_STAT, v); chk("R8 error without done", v, 32'h800);
    nand_rb_n = 1'b1;
    wr(A_CLR, 32'h1FFF);
    rd(A_STAT, v); chk("R10 clear error", v, 32'h0);

    // R9 queue overflow
    wr(A_TMO, 32'd1000);
    nand_rb_n = 1'b0;
    base = cap_cnt;
    wr(A_CMD, 32'h000D_00A0);
    for (int k = 1; k <= 5; k++) wr(A_CMD, 32'h0005_00A0 + k);
    idle(2);
    rd(A_STAT, v); chk("R9 overflow error", v[11], 1'b1);
    nand_rb_n = 1'b1;
    idle(80);
    chk("R9 strobes after drain", cap_cnt - base, 5);
    chk("R9 last byte in order", {22'd0, cap_buf[base+4]}, {22'd0, 10'h2A4});
    rd(A_STAT, v); chk("R9 done after drain", v, 32'hA00);
    wr(A_CLR, 32'h1FFF);

    // R10 clear in the same cycle as the done event
    wr(A_CMD, 32'h0005_0055);
    begin
      bit seen_low;
      seen_low = 0;
      forever begin
        @(negedge clk);
        if (!nand_we_n) seen_low = 1;
        else if (seen_low) break;
      end
    end
    @(negedge clk);
    @(negedge clk);
    reg_addr = A_CLR; reg_wdata = 32'h200; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = A_STAT;
    #1 chk("R10 set wins over clear", reg_rdata, 32'h200);
    wr(A_CLR, 32'h200);
    rd(A_STAT, v); chk("R10 isolated clear", v, 32'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule